// File: doc/BRIEF.md
# Seven-Level Interrupt Priority Arbiter

This block sits between a processor core and its interrupt request lines. It watches seven request levels, numbered 1 (lowest) to 7 (highest), picks the highest one pending and compares it with the interrupt mask level that the core holds in its status register. When the request is allowed through and the core says it can accept one, the arbiter issues a single-cycle take pulse along with the accepted level. The core then raises its mask to that level and enters its privileged mode. Vector fetch and the external acknowledge cycle are handled elsewhere.

Levels 1 to 6 are maskable. They are level-sensitive and pass only when their number is strictly above the current mask. Level 7 is non-maskable. It ignores the mask and is recognised on the rising edge of its line. Without that edge rule, a level-7 line held high would re-enter its handler without end. An edge seen while the core is not ready is remembered until it can be taken.

Top module: `irq_prio_arb`

## Requirements
- R1: Request bit i of `irq_req` is level i+1. An encoded level of 0 means nothing is pending. After reset, `take_o` is 0 and `take_level_o` is 0. A take never reports level 0.
- R2: When several levels are pending, the highest level number is the one taken.
- R3: A pending level from 1 to 6 is taken only if it is strictly greater than `cur_mask`. A level equal to or below the mask is blocked.
- R4: Level 7 is taken whatever the value of `cur_mask`, including a mask of 7.
- R5: Level 7 is taken once per rising edge of `irq_req[6]`. Holding the line high does not retrigger it. An edge that arrives while `core_ready` is low is remembered and taken once `core_ready` rises.
- R6: `take_o` rises only when `core_ready` was high at the deciding clock edge. It is registered: inputs present before edge k produce the pulse after edge k. It is one cycle wide and is never high in two consecutive cycles.
- R7: A lower request that loses arbitration, or that is blocked by the mask, stays pending. It is taken once the mask is lowered below it.
- R8: `take_level_o` changes only together with a take pulse. Between takes it holds the last accepted level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_req | input | 7 | Request lines; bit i is level i+1 |
| cur_mask | input | 3 | Current interrupt mask level from the status register |
| core_ready | input | 1 | Core can accept an interrupt this cycle |
| take_o | output | 1 | One-cycle interrupt-take pulse |
| take_level_o | output | 3 | Level accepted by the most recent take |

## Verification
The bench drives three kinds of request pattern:
- A single request swept against masks just below, equal to and above its level. This separates a strict comparison from a non-strict one.
- Two requests at once. These show that the higher level wins, and that the loser is still pending when the mask is later lowered below it.
- Level 7 held high, released and reasserted, both with `core_ready` high and with it low. These distinguish edge recognition from level recognition, show that the edge is remembered, and show that a mask of 7 is bypassed.

Holding `core_ready` low confirms that both the take pulse and the held level stay put.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  localparam int unsigned DEF_LEVELS = 7;
  localparam int unsigned DEF_LVL_W  = $clog2(DEF_LEVELS + 1);
  typedef logic [DEF_LVL_W-1:0] lvl_t;
endpackage

// File: rtl/irq_nmi_edge.sv
module irq_nmi_edge (
  input  logic clk,
  input  logic rst,
  input  logic req_top,
  input  logic clr,
  output logic pend_o
);
  logic prev_q;
  logic held_q;
  logic rise;

  assign rise   = req_top & ~prev_q;
  assign pend_o = held_q | rise;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= 1'b0;
      held_q <= 1'b0;
    end else begin
      prev_q <= req_top;
      held_q <= pend_o & ~clr;
    end
  end

  // R5: a remembered edge stays until it is consumed
  p_nmi_keep_r5: assert property (@(posedge clk) disable iff (rst)
    (held_q && !$past(clr)) |=> held_q || $past(clr));
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int unsigned NUM_LEVELS = 7,
  localparam int unsigned LVL_W = $clog2(NUM_LEVELS + 1)
) (
  input  logic [NUM_LEVELS-1:0] pend,
  output logic [LVL_W-1:0]      lvl
);
  always_comb begin
    lvl = '0;
    for (int i = 0; i < NUM_LEVELS; i++) begin
      if (pend[i]) lvl = LVL_W'(i + 1);
    end
  end
endmodule

// File: rtl/irq_take_ctrl.sv
module irq_take_ctrl #(
  parameter int unsigned NUM_LEVELS = 7,
  localparam int unsigned LVL_W = $clog2(NUM_LEVELS + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LVL_W-1:0] lvl,
  input  logic [LVL_W-1:0] mask,
  input  logic             ready,
  output logic             take_top_o,
  output logic             take_o,
  output logic [LVL_W-1:0] level_o
);
  localparam logic [LVL_W-1:0] TOP = LVL_W'(NUM_LEVELS);

  logic accept;
  logic go;

  assign accept     = (lvl == TOP) || (lvl > mask);
  assign go         = accept && ready && !take_o;
  assign take_top_o = go && (lvl == TOP);

  always_ff @(posedge clk) begin
    if (rst) begin
      take_o  <= 1'b0;
      level_o <= '0;
    end else begin
      take_o <= go;
      if (go) level_o <= lvl;
    end
  end

  // R6: pulse is one cycle wide
  p_pulse_width_r6: assert property (@(posedge clk) disable iff (rst)
    take_o |=> !take_o);
  // R6: take only after a ready cycle
  p_take_ready_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(take_o) |-> $past(ready));
endmodule

// File: rtl/irq_prio_arb.sv
module irq_prio_arb #(
  parameter int unsigned NUM_LEVELS = irq_arb_pkg::DEF_LEVELS,
  localparam int unsigned LVL_W = $clog2(NUM_LEVELS + 1)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NUM_LEVELS-1:0] irq_req,
  input  logic [LVL_W-1:0]      cur_mask,
  input  logic                  core_ready,
  output logic                  take_o,
  output logic [LVL_W-1:0]      take_level_o
);
  localparam logic [LVL_W-1:0] TOP = LVL_W'(NUM_LEVELS);

  logic [NUM_LEVELS-1:0] pend;
  logic [LVL_W-1:0]      best;
  logic                  top_pend;
  logic                  top_taken;

  irq_nmi_edge u_nmi (
    .clk     (clk),
    .rst     (rst),
    .req_top (irq_req[NUM_LEVELS-1]),
    .clr     (top_taken),
    .pend_o  (top_pend)
  );

  assign pend = {top_pend, irq_req[NUM_LEVELS-2:0]};

  irq_prio_enc #(.NUM_LEVELS(NUM_LEVELS)) u_enc (
    .pend (pend),
    .lvl  (best)
  );

  irq_take_ctrl #(.NUM_LEVELS(NUM_LEVELS)) u_ctl (
    .clk        (clk),
    .rst        (rst),
    .lvl        (best),
    .mask       (cur_mask),
    .ready      (core_ready),
    .take_top_o (top_taken),
    .take_o     (take_o),
    .level_o    (take_level_o)
  );

  // R1: a take never reports level 0
  p_nonzero_r1: assert property (@(posedge clk) disable iff (rst)
    take_o |-> take_level_o != '0);
  // R3: maskable takes exceed the mask seen at decision time
  p_mask_strict_r3: assert property (@(posedge clk) disable iff (rst)
    (take_o && take_level_o != TOP) |-> take_level_o > $past(cur_mask));
  // R8: level output only moves with a take
  p_level_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !take_o |-> $stable(take_level_o) || $past(rst));
endmodule

// File: tb/irq_prio_arb_test.sv
`timescale 1ns/1ps
module irq_prio_arb_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [6:0] irq_req = '0;
  logic [2:0] cur_mask = '0;
  logic       core_ready = 1'b0;
  logic       take_o;
  logic [2:0] take_level_o;
  int n_cmp = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  irq_prio_arb uut (
    .clk(clk), .rst(rst), .irq_req(irq_req), .cur_mask(cur_mask),
    .core_ready(core_ready), .take_o(take_o), .take_level_o(take_level_o)
  );

  task automatic check(input logic et, input logic [2:0] el, input string rq);
    n_cmp++;
    if (take_o !== et || take_level_o !== el) begin
      n_bad++;
      $display("FAIL %s: take=%0b level=%0d expected take=%0b level=%0d",
               rq, take_o, take_level_o, et, el);
    end
  endtask

  task automatic drive(input logic [6:0] r, input logic [2:0] m, input logic rd);
    irq_req = r; cur_mask = m; core_ready = rd;
  endtask

  task automatic idle();
    drive(7'b0, 3'd0, 1'b0);
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    check(1'b0, 3'd0, "R1 reset");
  endtask

  task automatic t_mask_sweep();
    @(negedge clk); drive(7'b0001000, 3'd4, 1'b1);   // level 4, mask 4
    @(negedge clk); check(1'b0, 3'd0, "R3 equal mask blocks");
    drive(7'b0001000, 3'd5, 1'b1);
    @(negedge clk); check(1'b0, 3'd0, "R3 higher mask blocks");
    drive(7'b0001000, 3'd3, 1'b1);
    @(negedge clk); check(1'b1, 3'd4, "R3 level above mask taken");
    idle();
    drive(7'b0000001, 3'd0, 1'b1);                    // level 1, mask 0
    @(negedge clk); check(1'b1, 3'd1, "R1 level 1 over mask 0");
    idle();
  endtask

  task automatic t_multi();
    drive(7'b0010010, 3'd0, 1'b1);                    // levels 2 and 5
    @(negedge clk); check(1'b1, 3'd5, "R2 highest of 2 and 5");
    drive(7'b0010010, 3'd5, 1'b1);
    @(negedge clk); check(1'b0, 3'd5, "R6 no back-to-back take");
    @(negedge clk); check(1'b0, 3'd5, "R7 lower blocked by raised mask");
    drive(7'b0000010, 3'd1, 1'b1);
    @(negedge clk); check(1'b1, 3'd2, "R7 lower taken after mask lowered");
    idle();
  endtask

  task automatic t_nmi();
    drive(7'b0100000, 3'd7, 1'b1);                    // level 6, mask 7
    @(negedge clk); check(1'b0, 3'd2, "R3 level 6 blocked by mask 7");
    drive(7'b1000000, 3'd7, 1'b1);
    @(negedge clk); check(1'b1, 3'd7, "R4 level 7 over mask 7");
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); check(1'b0, 3'd7, "R5 held level 7 no retrigger");
    end
    drive(7'b0000000, 3'd7, 1'b0);
    @(negedge clk);
    drive(7'b1000000, 3'd7, 1'b0);
    @(negedge clk); check(1'b0, 3'd7, "R6 not ready no take");
    drive(7'b1000000, 3'd0, 1'b0);
    @(negedge clk); check(1'b0, 3'd7, "R6 still not ready");
    drive(7'b1000000, 3'd0, 1'b1);
    @(negedge clk); check(1'b1, 3'd7, "R5 remembered edge taken");
    @(negedge clk); check(1'b0, 3'd7, "R5 consumed edge");
    @(negedge clk); check(1'b0, 3'd7, "R5 still consumed");
    idle();
  endtask

  task automatic t_ready_hold();
    drive(7'b0001000, 3'd0, 1'b0);
    @(negedge clk); check(1'b0, 3'd7, "R8 level held while not ready");
    @(negedge clk); check(1'b0, 3'd7, "R6 no take without ready");
    core_ready = 1'b1;
    @(negedge clk); check(1'b1, 3'd4, "R6 take once ready");
    @(negedge clk); check(1'b0, 3'd4, "R6 pulse one cycle");
    idle();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_mask_sweep();
    t_multi();
    t_nmi();
    t_ready_hold();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: take=%0b level=%0d expected completion", take_o, take_level_o);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule